// File: doc/BRIEF.md
# Bidirectional Dual-Chain Column Driver Core

This block is the logic core of a 64-channel serial-to-parallel column driver for a display panel. Two 32-stage shift chains advance on the same clock, so each rising edge moves in two bits, one per chain. Chain 0 feeds channels 1 to 32 and chain 1 feeds channels 33 to 64. A direction input picks which end of each chain takes data. The serial pins at either end of a chain swap between input and output roles to match. Each pin is modelled as a separate input, output and output-enable.

A bank of 64 latches captures the chain contents while the latch enable is high and holds them while it is low. The channel outputs are active-high "channel on" bits. A latched 0 turns a channel on and a latched 1 turns it off. Pulling the blanking input low forces every channel on. The end stage of each chain is always visible on a serial output, so several devices can be cascaded.

Top module: `dcd_top`

## Requirements
- R1: On every rising clock edge outside reset, both chains shift by exactly one stage at the same time. Each chain takes one new bit.
- R2: With `dir_fwd` = 1, chain k loads `ser_a_in[k]` into stage 0 and moves every bit one stage toward stage 31. Stage i of chain k drives channel index k*32+i, where index 0 is channel 1.
- R3: With `dir_fwd` = 0, chain k loads `ser_b_in[k]` into stage 31 and moves every bit one stage toward stage 0.
- R4: With `dir_fwd` = 1, every `ser_b_oe` bit is 1 and every `ser_a_oe` bit is 0. With `dir_fwd` = 0 the enables are the other way round.
- R5: In every cycle, `ser_b_out[k]` equals stage 31 of chain k and `ser_a_out[k]` equals stage 0 of chain k.
- R6: While `latch_en` = 1, each rising edge loads all 64 latches with the chain contents as they stood just before that edge.
- R7: While `latch_en` = 0, the latches keep their contents across clock edges, even while the chains shift.
- R8: While `blank_n` = 1, `chan_on[i]` is the inverse of latch bit i.
- R9: While `blank_n` = 0, all 64 `chan_on` bits are 1, whatever the latches hold.
- R10: `latch_en` and `blank_n` have no effect on shifting.
- R11: A rising edge with `rst` = 1 clears both chains and all latches to 0. Afterwards, with `blank_n` = 1, every channel reads on and the serial outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | 1: forward shift (A end in), 0: reverse shift (B end in) |
| ser_a_in | input | 2 | Serial data into the A end of each chain |
| ser_b_in | input | 2 | Serial data into the B end of each chain |
| ser_a_out | output | 2 | Stage 0 of each chain |
| ser_b_out | output | 2 | Stage 31 of each chain |
| ser_a_oe | output | 2 | Drive enable for the A-end pins |
| ser_b_oe | output | 2 | Drive enable for the B-end pins |
| latch_en | input | 1 | 1: latches load on each edge, 0: latches hold |
| blank_n | input | 1 | 0: force all channels on |
| chan_on | output | 64 | Channel on bits, index 0 is channel 1 |

## Verification
Chain and latch contents change on the rising edge that samples the inputs. The serial outputs therefore show a new bit in the cycle after it was driven. A latch load shows on `chan_on` one edge after `latch_en` was high. The enables and the blanking override are combinational and must follow their inputs within the same cycle. The bench drives every input on the falling edge and steps its queue-based reference model on the rising edge. It then compares every output on the next falling edge, so each result is checked in the first cycle it is due. The comparisons run in both shift directions, across direction reversals, during latch holds, with blanking active and across a reset in the middle of a run.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int CHAIN_LEN_DEF  = 32;
    localparam int NUM_CHAINS_DEF = 2;

    typedef enum logic {
        DIR_REV = 1'b0,
        DIR_FWD = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic a_oe;
        logic b_oe;
    } pin_roles_t;

    function automatic pin_roles_t roles_for(input shift_dir_e d);
        pin_roles_t r;
        r.a_oe = (d == DIR_REV);
        r.b_oe = (d == DIR_FWD);
        return r;
    endfunction

    function automatic logic chan_level(input logic blank_n, input logic stored);
        return blank_n ? ~stored : 1'b1;
    endfunction

endpackage

// File: rtl/dcd_shift_chain.sv
module dcd_shift_chain
    import dcd_pkg::*;
#(
    parameter int LEN = CHAIN_LEN_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  shift_dir_e     dir,
    input  logic           a_in,
    input  logic           b_in,
    output logic [LEN-1:0] stage
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (dir == DIR_FWD) begin
            stage <= {stage[LEN-2:0], a_in};
        end else begin
            stage <= {b_in, stage[LEN-1:1]};
        end
    end

    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_FWD) |=> (stage[0] == $past(a_in)));                         // R2
    AST_FWD_MOVE: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_FWD) |=> (stage[LEN-1:1] == $past(stage[LEN-2:0])));         // R1
    AST_REV_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_REV) |=> (stage[LEN-1] == $past(b_in)));                     // R3
    AST_REV_MOVE: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_REV) |=> (stage[LEN-2:0] == $past(stage[LEN-1:1])));         // R1

endmodule

// File: rtl/dcd_latch_bank.sv
module dcd_latch_bank #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));                                               // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> (q == $past(q)));                                              // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0));                                                      // R11

endmodule

// File: rtl/dcd_chan_gate.sv
module dcd_chan_gate
    import dcd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         blank_n,
    input  logic [W-1:0] stored,
    output logic [W-1:0] chan_on
);

    for (genvar i = 0; i < W; i++) begin : g_chan
        assign chan_on[i] = chan_level(blank_n, stored[i]);
    end

    always_comb begin
        if (!blank_n) begin
            AST_BLANK_ALL_ON: assert (&chan_on);                                 // R9
        end
    end

endmodule

// File: rtl/dcd_top.sv
module dcd_top
    import dcd_pkg::*;
#(
    parameter int CHAIN_LEN  = CHAIN_LEN_DEF,
    parameter int NUM_CHAINS = NUM_CHAINS_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dir_fwd,
    input  logic [NUM_CHAINS-1:0] ser_a_in,
    input  logic [NUM_CHAINS-1:0] ser_b_in,
    output logic [NUM_CHAINS-1:0] ser_a_out,
    output logic [NUM_CHAINS-1:0] ser_b_out,
    output logic [NUM_CHAINS-1:0] ser_a_oe,
    output logic [NUM_CHAINS-1:0] ser_b_oe,
    input  logic                  latch_en,
    input  logic                  blank_n,
    output logic [NUM_CHAINS*CHAIN_LEN-1:0] chan_on
);

    localparam int NCH = NUM_CHAINS * CHAIN_LEN;

    shift_dir_e       dir;
    pin_roles_t       roles;
    logic [NCH-1:0]   sr_all;
    logic [NCH-1:0]   lat_q;

    assign dir   = dir_fwd ? DIR_FWD : DIR_REV;
    assign roles = roles_for(dir);

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        logic [CHAIN_LEN-1:0] stg;

        dcd_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
            .clk   (clk),
            .rst   (rst),
            .dir   (dir),
            .a_in  (ser_a_in[k]),
            .b_in  (ser_b_in[k]),
            .stage (stg)
        );

        assign sr_all[k*CHAIN_LEN +: CHAIN_LEN] = stg;
        assign ser_a_out[k] = stg[0];
        assign ser_b_out[k] = stg[CHAIN_LEN-1];
        assign ser_a_oe[k]  = roles.a_oe;
        assign ser_b_oe[k]  = roles.b_oe;
    end

    dcd_latch_bank #(.W(NCH)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (latch_en),
        .d    (sr_all),
        .q    (lat_q)
    );

    dcd_chan_gate #(.W(NCH)) u_gate (
        .blank_n (blank_n),
        .stored  (lat_q),
        .chan_on (chan_on)
    );

    AST_PIN_ROLES: assert property (@(posedge clk) disable iff (rst)
        (ser_a_oe[0] != ser_b_oe[0]) && (ser_b_oe[0] == dir_fwd));               // R4

endmodule

// File: tb/tb_dcd_top.sv
`timescale 1ns/1ps
module tb_dcd_top;

    localparam int LEN = 32;
    localparam int NC  = 2;
    localparam int NCH = LEN * NC;

    logic           clk = 1'b0;
    logic           rst;
    logic           dir_fwd;
    logic [NC-1:0]  ser_a_in, ser_b_in;
    logic [NC-1:0]  ser_a_out, ser_b_out, ser_a_oe, ser_b_oe;
    logic           latch_en, blank_n;
    logic [NCH-1:0] chan_on;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit cq [NC][$];
    bit lat_m [NCH];

    always #2 clk = ~clk;

    dcd_top dut (
        .clk(clk), .rst(rst), .dir_fwd(dir_fwd),
        .ser_a_in(ser_a_in), .ser_b_in(ser_b_in),
        .ser_a_out(ser_a_out), .ser_b_out(ser_b_out),
        .ser_a_oe(ser_a_oe), .ser_b_oe(ser_b_oe),
        .latch_en(latch_en), .blank_n(blank_n), .chan_on(chan_on)
    );

    task automatic check(input string tag, input string what,
                         input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int k = 0; k < NC; k++) begin
                cq[k].delete();
                for (int i = 0; i < LEN; i++) cq[k].push_back(1'b0);
            end
            for (int c = 0; c < NCH; c++) lat_m[c] = 1'b0;
            return;
        end
        if (latch_en)
            for (int c = 0; c < NCH; c++) lat_m[c] = cq[c / LEN][c % LEN];
        for (int k = 0; k < NC; k++) begin
            if (dir_fwd) begin
                cq[k].push_front(ser_a_in[k]);
                void'(cq[k].pop_back());
            end else begin
                cq[k].push_back(ser_b_in[k]);
                void'(cq[k].pop_front());
            end
        end
    endtask

    task automatic compare_all(input string tag);
        logic [NCH-1:0] exp_on;
        logic [NC-1:0]  exp_a, exp_b;
        for (int c = 0; c < NCH; c++) exp_on[c] = blank_n ? ~lat_m[c] : 1'b1;
        for (int k = 0; k < NC; k++) begin
            exp_a[k] = cq[k][0];
            exp_b[k] = cq[k][LEN-1];
        end
        check(tag, "chan_on", chan_on, exp_on);
        check("R5", "ser_a_out", NCH'(ser_a_out), NCH'(exp_a));
        check("R5", "ser_b_out", NCH'(ser_b_out), NCH'(exp_b));
        check("R4", "ser_a_oe", NCH'(ser_a_oe), NCH'({NC{~dir_fwd}}));
        check("R4", "ser_b_oe", NCH'(ser_b_oe), NCH'({NC{dir_fwd}}));
    endtask

    // Inputs are applied at a falling edge, the model steps at the rising edge,
    // and outputs are compared at the following falling edge.
    task automatic step(input string tag, input logic r, input logic d,
                        input logic [NC-1:0] a, input logic [NC-1:0] b,
                        input logic le, input logic bl);
        rst = r; dir_fwd = d; ser_a_in = a; ser_b_in = b;
        latch_en = le; blank_n = bl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        rst = 1'b1; dir_fwd = 1'b1; ser_a_in = '0; ser_b_in = '0;
        latch_en = 1'b0; blank_n = 1'b1;
        for (int k = 0; k < NC; k++) cq[k] = {};
        @(negedge clk);
        repeat (2) step("R11", 1'b1, 1'b1, '0, '0, 1'b0, 1'b1);
        // R11: after reset every channel reads on and the ends read 0
        check("R11", "reset chan_on", chan_on, {NCH{1'b1}});

        // R2: forward fill with a walking pattern, latches transparent
        for (int n = 0; n < 40; n++)
            step("R2", 1'b0, 1'b1, NC'(n % 3 == 0 ? 2'b01 : 2'b10), 2'b11, 1'b1, 1'b1);
        // R6: single-cycle load pulse after random fill
        for (int n = 0; n < 10; n++)
            step("R6", 1'b0, 1'b1, NC'($urandom), NC'($urandom), 1'b0, 1'b1);
        step("R6", 1'b0, 1'b1, 2'b11, 2'b00, 1'b1, 1'b1);
        // R7: hold while shifting a lot
        for (int n = 0; n < 50; n++)
            step("R7", 1'b0, 1'b1, NC'($urandom), NC'($urandom), 1'b0, 1'b1);
        // R3: reverse shifting
        for (int n = 0; n < 45; n++)
            step("R3", 1'b0, 1'b0, NC'($urandom), NC'($urandom), 1'b1, 1'b1);
        // R9: blanking low with various latch contents
        for (int n = 0; n < 20; n++)
            step("R9", 1'b0, 1'b0, NC'($urandom), NC'($urandom), n[0], 1'b0);
        // R8: blanking high, inverse of stored data
        for (int n = 0; n < 10; n++)
            step("R8", 1'b0, 1'b1, NC'($urandom), NC'($urandom), 1'b1, 1'b1);
        // R10: latch enable and blanking toggle while shifting continues
        for (int n = 0; n < 60; n++)
            step("R10", 1'b0, n[3], NC'($urandom), NC'($urandom), n[0], n[1]);
        // R1: random direction reversals, both chains move together
        for (int n = 0; n < 120; n++)
            step("R1", 1'b0, 1'($urandom), NC'($urandom), NC'($urandom),
                 1'($urandom), 1'($urandom));
        // R11: reset in mid-run
        step("R11", 1'b1, 1'b0, 2'b11, 2'b11, 1'b1, 1'b1);
        check("R11", "mid reset chan_on", chan_on, {NCH{1'b1}});
        check("R11", "mid reset ends", NCH'({ser_a_out, ser_b_out}), '0);
        for (int n = 0; n < 20; n++)
            step("R2", 1'b0, 1'b1, NC'($urandom), NC'($urandom), 1'b1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule